// File: doc/BRIEF.md
# Three-Stage Pipeline Sequencer with On-Demand Second Execute Cycle

This block steers a small in-order processor pipeline with three stages: fetch, execute and writeback. Each cycle it takes the class of the instruction sitting in fetch and drives the control signals for the rest of the core. These are the stage valid bits, the fetch accept strobe, the register-file write enable, the fetch address, and the operand-select code for the one adder. That adder serves ALU work, data addresses and the next fetch address.

Memory transfers and coprocessor moves stay in execute for a second cycle (X2), which is added only for them. While X2 runs, fetch and execute hold and writeback receives a bubble. All other classes finish execute in one cycle (X1). A taken branch resolved in X1 redirects fetch to the adder result and discards the instruction that was being fetched. Short (16-bit) instructions advance the fetch address by 2 and full-width ones by 4.

Top module: `pipe_seq`

## Requirements
- R1: While rst_ni is low, all four stage valid outputs, fetch_adv_o and rf_we_o are 0 and pc_o is 0. On the first clock edge after reset is released, if_valid_o becomes 1 and pc_o stays 0.
- R2: An instruction accepted from fetch (fetch_adv_o high) is in X1 on the next cycle. An instruction that leaves execute is in writeback on the next cycle (wb_valid_o high).
- R3: add_sel_o is 1 (ALU) when X1 holds an ALU or branch instruction. It is 2 (address) when X1 holds a load or store. It is 0 (fetch increment) in every other cycle, including X2 cycles, empty X1 cycles and X1 cycles of a coprocessor move.
- R4: Instruction class codes are ALU=0, branch=1, load=2, store=3, coprocessor move=4; codes 5 to 7 act as ALU. A load, store or coprocessor move in X1 is followed by exactly one cycle with x2_valid_o high and x1_valid_o low. In its X1 cycle fetch_adv_o is 0 and pc_o holds. In the X2 cycle wb_valid_o is 0. ALU and branch instructions never enter X2.
- R5: When fetch advances, pc_o increases by 2 if f_short_i is 1 and by 4 otherwise. When add_sel_o is 0 the new address is taken from add_res_i.
- R6: If X1 holds a branch and br_taken_i is 1, then on the next cycle pc_o equals the add_res_i value of the branch cycle, x1_valid_o is 0, and fetch_adv_o was 0 in the branch cycle.
- R7: rf_we_o is 1 exactly when writeback holds a valid ALU, load or coprocessor-move instruction. Stores and branches never write.
- R8: A branch with br_taken_i 0 does not flush: the next fetched instruction enters X1 in sequence.
- R9: br_taken_i has no effect when X1 does not hold a branch in its X1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| f_class_i | input | 3 | Class of the instruction in fetch |
| f_short_i | input | 1 | Instruction in fetch is a 16-bit form |
| br_taken_i | input | 1 | Branch condition outcome for X1 |
| add_res_i | input | AW | Result of the shared adder this cycle |
| pc_o | output | AW | Current fetch address |
| add_sel_o | output | 2 | Shared adder user: 0 fetch increment, 1 ALU, 2 data address |
| fetch_adv_o | output | 1 | Fetch instruction is accepted into X1 at this edge |
| if_valid_o | output | 1 | Fetch stage holds a valid instruction |
| x1_valid_o | output | 1 | Execute stage in its first cycle |
| x2_valid_o | output | 1 | Execute stage in its second cycle |
| wb_valid_o | output | 1 | Writeback stage holds a valid instruction |
| rf_we_o | output | 1 | Register-file write enable |

## Verification
The hardest case to reach from the ports is a taken branch whose redirect meets a stall or a just-released reset. Another is br_taken_i asserted while execute holds something other than a branch in X1. The bench drives fetch from a small program image indexed by its own model of the fetch address. It places branches right after loads and coprocessor moves, so redirects land next to X2 cycles. In one scenario it holds br_taken_i high whenever X1 holds no branch, and every cycle is compared with the model.

// File: rtl/pipe_seq_pkg.sv
package pipe_seq_pkg;
  typedef enum logic [2:0] {
    CLS_ALU = 3'd0,
    CLS_BR  = 3'd1,
    CLS_LD  = 3'd2,
    CLS_ST  = 3'd3,
    CLS_COP = 3'd4
  } icls_e;

  typedef enum logic [1:0] {
    SEL_PC   = 2'd0,
    SEL_ALU  = 2'd1,
    SEL_ADDR = 2'd2
  } asel_e;

  function automatic logic needs_x2(logic [2:0] c);
    return (c == CLS_LD) || (c == CLS_ST) || (c == CLS_COP);
  endfunction

  function automatic logic writes_rf(logic [2:0] c);
    return (c != CLS_BR) && (c != CLS_ST);
  endfunction

  function automatic asel_e x1_sel(logic [2:0] c);
    if (c == CLS_LD || c == CLS_ST) return SEL_ADDR;
    if (c == CLS_COP)               return SEL_PC;
    return SEL_ALU;
  endfunction
endpackage

// File: rtl/seq_fetch.sv
module seq_fetch #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          redirect_i,
  input  logic [AW-1:0] target_i,
  input  logic          adder_free_i,
  input  logic [AW-1:0] add_res_i,
  input  logic          short_i,
  output logic          if_valid_o,
  output logic [AW-1:0] pc_o,
  output logic          accept_o
);
  localparam logic [AW-1:0] STEP_S = AW'(2);
  localparam logic [AW-1:0] STEP_L = AW'(4);

  logic [AW-1:0] pc_q, seq_next;
  logic          v_q;

  // adder busy in X1: fall back to the local step path
  assign seq_next = adder_free_i ? add_res_i : pc_q + (short_i ? STEP_S : STEP_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      v_q  <= 1'b0;
    end else if (!hold_i) begin
      v_q <= 1'b1;
      if (redirect_i)  pc_q <= target_i;
      else if (v_q)    pc_q <= seq_next;
    end
  end

  assign if_valid_o = v_q;
  assign pc_o       = pc_q;
  assign accept_o   = !hold_i && v_q && !redirect_i;
endmodule

// File: rtl/seq_exec.sv
module seq_exec
  import pipe_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_valid_i,
  input  logic [2:0] in_cls_i,
  input  logic       br_taken_i,
  output logic       x1_valid_o,
  output logic       x2_valid_o,
  output logic       occ_o,
  output logic [2:0] cls_o,
  output logic       need_x2_o,
  output logic       taken_o,
  output logic [1:0] add_sel_o
);
  logic       v_q, ph2_q;
  logic [2:0] cls_q;
  logic       in_x1;

  assign in_x1     = v_q && !ph2_q;
  assign need_x2_o = in_x1 && needs_x2(cls_q);
  assign taken_o   = in_x1 && (cls_q == CLS_BR) && br_taken_i;
  assign add_sel_o = in_x1 ? x1_sel(cls_q) : SEL_PC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q   <= 1'b0;
      ph2_q <= 1'b0;
      cls_q <= CLS_ALU;
    end else if (need_x2_o) begin
      ph2_q <= 1'b1;
    end else begin
      ph2_q <= 1'b0;
      v_q   <= in_valid_i;
      if (in_valid_i) cls_q <= in_cls_i;
    end
  end

  assign x1_valid_o = in_x1;
  assign x2_valid_o = v_q && ph2_q;
  assign occ_o      = v_q;
  assign cls_o      = cls_q;
endmodule

// File: rtl/seq_wb.sv
module seq_wb
  import pipe_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       in_valid_i,
  input  logic [2:0] in_cls_i,
  output logic       wb_valid_o,
  output logic       rf_we_o
);
  logic       v_q;
  logic [2:0] cls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q   <= 1'b0;
      cls_q <= CLS_ALU;
    end else begin
      v_q <= adv_i && in_valid_i;  // bubble while X2 runs
      if (adv_i) cls_q <= in_cls_i;
    end
  end

  assign wb_valid_o = v_q;
  assign rf_we_o    = v_q && writes_rf(cls_q);
endmodule

// File: rtl/pipe_seq.sv
module pipe_seq
  import pipe_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    f_class_i,
  input  logic          f_short_i,
  input  logic          br_taken_i,
  input  logic [AW-1:0] add_res_i,
  output logic [AW-1:0] pc_o,
  output logic [1:0]    add_sel_o,
  output logic          fetch_adv_o,
  output logic          if_valid_o,
  output logic          x1_valid_o,
  output logic          x2_valid_o,
  output logic          wb_valid_o,
  output logic          rf_we_o
);
  logic       need_x2, taken, accept, x_occ;
  logic [2:0] x_cls;

  seq_fetch #(.AW(AW)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hold_i       (need_x2),
    .redirect_i   (taken),
    .target_i     (add_res_i),
    .adder_free_i (add_sel_o == SEL_PC),
    .add_res_i    (add_res_i),
    .short_i      (f_short_i),
    .if_valid_o   (if_valid_o),
    .pc_o         (pc_o),
    .accept_o     (accept)
  );

  seq_exec u_exec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (accept),
    .in_cls_i   (f_class_i),
    .br_taken_i (br_taken_i),
    .x1_valid_o (x1_valid_o),
    .x2_valid_o (x2_valid_o),
    .occ_o      (x_occ),
    .cls_o      (x_cls),
    .need_x2_o  (need_x2),
    .taken_o    (taken),
    .add_sel_o  (add_sel_o)
  );

  seq_wb u_wb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (!need_x2),
    .in_valid_i (x_occ),
    .in_cls_i   (x_cls),
    .wb_valid_o (wb_valid_o),
    .rf_we_o    (rf_we_o)
  );

  assign fetch_adv_o = accept;

  assert_x2_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    need_x2 |=> x2_valid_o && !x1_valid_o && $stable(pc_o));
  assert_wb_bubble_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x2_valid_o |-> !wb_valid_o);
  assert_flush_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken |=> !x1_valid_o && pc_o == $past(add_res_i));
  assert_we_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> wb_valid_o);
  assert_sel_owner_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_sel_o != SEL_PC |-> x1_valid_o);
  assert_accept_flow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_adv_o |=> x1_valid_o);
endmodule

// File: tb/pipe_seq_tb.sv
module pipe_seq_tb;
  localparam int AW = 32;
  localparam logic [31:0] JUNK = 32'hDEAD_BEE0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    f_class = '0;
  logic          f_short = 1'b0;
  logic          br_taken = 1'b0;
  logic [AW-1:0] add_res = '0;
  logic [AW-1:0] pc;
  logic [1:0]    add_sel;
  logic          fetch_adv, if_v, x1_v, x2_v, wb_v, rf_we;

  pipe_seq #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .f_class_i(f_class), .f_short_i(f_short),
    .br_taken_i(br_taken), .add_res_i(add_res), .pc_o(pc), .add_sel_o(add_sel),
    .fetch_adv_o(fetch_adv), .if_valid_o(if_v), .x1_valid_o(x1_v),
    .x2_valid_o(x2_v), .wb_valid_o(wb_v), .rf_we_o(rf_we)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [2:0] p_cls [64];
  logic       p_sh  [64];
  logic       p_tk  [64];
  logic [31:0] tgt;
  bit spur;

  // reference state
  logic [31:0] m_pc;
  logic m_ifv, m_x1v, m_ph2, m_wbv, m_x1tk;
  logic [2:0] m_x1cls, m_wbcls;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit m_writes(logic [2:0] c);
    return c != 3'd1 && c != 3'd3;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    {m_pc, m_ifv, m_x1v, m_ph2, m_wbv, m_x1tk} = '0;
    m_x1cls = '0; m_wbcls = '0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(!if_v && !x1_v && !x2_v && !wb_v, "R1", "valids in reset",
        {if_v, x1_v, x2_v, wb_v}, 0);
    chk(pc == 0, "R1", "pc in reset", pc, 0);
    chk(!rf_we && !fetch_adv, "R1", "we/adv in reset", {rf_we, fetch_adv}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run(int ncyc);
    for (int c = 0; c < ncyc; c++) begin
      logic busy, nx2, tk;
      logic [1:0] esel;
      logic [31:0] step;
      int idx;
      idx  = int'(m_pc[6:1]);
      busy = m_x1v && !m_ph2;
      f_class = p_cls[idx];
      f_short = p_sh[idx];
      step = p_sh[idx] ? 32'd2 : 32'd4;
      br_taken = (busy && m_x1cls == 3'd1) ? m_x1tk : spur;
      if (!busy) esel = 2'd0;
      else if (m_x1cls == 3'd2 || m_x1cls == 3'd3) esel = 2'd2;
      else if (m_x1cls == 3'd4) esel = 2'd0;
      else esel = 2'd1;
      if (esel == 2'd0) add_res = m_pc + step;
      else if (m_x1cls == 3'd1) add_res = tgt;
      else add_res = JUNK;
      nx2 = busy && (m_x1cls == 3'd2 || m_x1cls == 3'd3 || m_x1cls == 3'd4);
      tk  = busy && m_x1cls == 3'd1 && m_x1tk;
      #1;
      chk(if_v == m_ifv, "R1", "if_valid", 32'(if_v), 32'(m_ifv));
      chk(x1_v == busy, "R2", "x1_valid", 32'(x1_v), 32'(busy));
      chk(x2_v == (m_x1v && m_ph2), "R4", "x2_valid", 32'(x2_v), 32'(m_x1v && m_ph2));
      chk(wb_v == m_wbv, "R2", "wb_valid", 32'(wb_v), 32'(m_wbv));
      chk(add_sel == esel, "R3", "add_sel", 32'(add_sel), 32'(esel));
      chk(pc == m_pc, tk ? "R6" : "R5", "pc", pc, m_pc);
      chk(fetch_adv == (!nx2 && m_ifv && !tk), "R4", "fetch_adv",
          32'(fetch_adv), 32'(!nx2 && m_ifv && !tk));
      chk(rf_we == (m_wbv && m_writes(m_wbcls)), "R7", "rf_we",
          32'(rf_we), 32'(m_wbv && m_writes(m_wbcls)));
      if (nx2) begin
        m_ph2 = 1'b1;
        m_wbv = 1'b0;
      end else begin
        m_wbv = m_x1v; m_wbcls = m_x1cls; m_ph2 = 1'b0;
        if (tk) begin
          m_x1v = 1'b0; m_pc = tgt; m_ifv = 1'b1;
        end else if (!m_ifv) begin
          m_x1v = 1'b0; m_ifv = 1'b1;
        end else begin
          m_x1v = 1'b1; m_x1cls = p_cls[idx]; m_x1tk = p_tk[idx];
          m_pc = m_pc + step;
        end
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 64; i++) begin p_cls[i] = 3'd0; p_sh[i] = 1'b0; p_tk[i] = 1'b0; end
    tgt = 32'h40; spur = 1'b0;
    do_reset();
    run(1);
    // R1: after first edge fetch valid, pc still 0
    chk(if_v == 1'b1, "R1", "if_valid after release", 32'(if_v), 1);
    chk(pc == 0, "R1", "pc after release", pc, 0);
  endtask

  task automatic t_alu();
    for (int i = 0; i < 64; i++) begin p_cls[i] = (i % 7 == 6) ? 3'd5 : 3'd0; p_sh[i] = (i % 3 == 0); p_tk[i] = 1'b0; end
    spur = 1'b0;
    do_reset();
    run(60);   // R2 R5 R3
  endtask

  task automatic t_mem();
    for (int i = 0; i < 64; i++) begin
      case (i % 5)
        0: p_cls[i] = 3'd0; 1: p_cls[i] = 3'd2; 2: p_cls[i] = 3'd3;
        3: p_cls[i] = 3'd4; default: p_cls[i] = 3'd0;
      endcase
      p_sh[i] = i[0]; p_tk[i] = 1'b0;
    end
    spur = 1'b0;
    do_reset();
    run(80);   // R4 R7
  endtask

  task automatic t_branch();
    for (int i = 0; i < 64; i++) begin
      case (i % 4)
        1: p_cls[i] = 3'd2; 2: p_cls[i] = 3'd4; 3: p_cls[i] = 3'd1;
        default: p_cls[i] = 3'd0;
      endcase
      p_sh[i] = (i % 3 == 1); p_tk[i] = 1'b1;
    end
    tgt = 32'h40; spur = 1'b0;
    do_reset();
    run(80);   // R6 next to X2 cycles
  endtask

  task automatic t_not_taken();
    for (int i = 0; i < 64; i++) begin
      p_cls[i] = (i % 3 == 2) ? 3'd1 : ((i % 3 == 1) ? 3'd3 : 3'd0);
      p_sh[i] = (i % 4 == 0); p_tk[i] = 1'b0;
    end
    tgt = 32'h20; spur = 1'b1;   // R9: taken flag high outside branch X1
    do_reset();
    run(80);   // R8 R9
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_alu();
    t_mem();
    t_branch();
    t_not_taken();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule